// File: doc/BRIEF.md
# Display Controller Processor Register Interface

This block is the processor-facing side of a raster display controller. A host reaches it through four control lines (an active-low chip select, an active-high enable, a read/write line and a register-select line) plus an 8-bit data bus. Together these pick one of four bus operations. The host first loads a 5-bit pointer, then writes or reads the register that the pointer names. It can also fetch a status byte.

Sixteen programmable registers, indices 0 to 15, hold the timing, mode, start-address and cursor settings. Their contents go straight to a separate timing generator as one flat bus. Two further registers, 16 and 17, are filled only by hardware: a light-pen strobe copies the timing generator's current 14-bit memory address into them. The status byte carries three flags:

- an update-ready flag, driven by an update strobe;
- a light-pen-full flag;
- the live vertical-blanking level.

Each flag clears on its own access rule.

Top module: `crtc_cpu_regif`

## Requirements
- R1: The bus is active only in a cycle with `cs_n`=0 and `en`=1. In an active cycle, {`rw`,`rs`} selects the operation: 2'b00 loads the pointer, 2'b01 writes a register, 2'b10 reads status, 2'b11 reads a register. Inactive cycles change no state.
- R2: A pointer load keeps `wdata[4:0]` as the register index and ignores bits 7:5, so the index is taken modulo 32.
- R3: A register write to index 0..15 takes effect at the clock edge that ends the access cycle. The value is stored masked to the register's width, with the upper bits zero. Widths: indices 0,1,2,3,8,13,15 are 8 bits; 4,6,7,10 are 7 bits; 5,9,11 are 5 bits; 12,14 are 6 bits. Byte k of `cfg_regs` (bits 8k+7:8k) shows register k.
- R4: A register write with the pointer at 16..31 changes nothing.
- R5: A register read returns the following:
  - with the pointer at 10..15, the stored value;
  - at 16 and 17, the light-pen high and low bytes;
  - at any other index, 0x00.
  `rdata` is 0x00 in any cycle that is not a read.
- R6: A status read returns bit 7 update-ready, bit 6 light-pen-full, bit 5 the present `vblank_in`, and bits 4:0 zero. A status read clears nothing.
- R7: `update_stb` sets update-ready at the next edge. A register write or register read with the pointer at 31 clears it. If a strobe and a clearing access fall in the same cycle, the flag stays set.
- R8: `lpen_stb` copies `cur_addr[13:8]` into register 16 (zero-extended) and `cur_addr[7:0]` into register 17 at the next edge, and sets light-pen-full.
- R9: A register read with the pointer at 16 or 17 clears light-pen-full. If `lpen_stb` falls in the same cycle, the flag stays set and the read returns the value held before the capture.
- R10: Reset clears the pointer, all registers and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| en | input | 1 | Bus enable, active high |
| rw | input | 1 | Operation select, upper bit |
| rs | input | 1 | Operation select, lower bit |
| wdata | input | 8 | Data from the host |
| rdata | output | 8 | Data to the host, zero when not reading |
| update_stb | input | 1 | Update strobe, sets update-ready |
| lpen_stb | input | 1 | Light-pen strobe |
| vblank_in | input | 1 | Vertical blanking level from the timing generator |
| cur_addr | input | 14 | Current memory address from the timing generator |
| cfg_regs | output | 128 | Registers 0..15, one byte each, to the timing generator |

## Verification
Two pairs of events can fall in the same cycle. In the first, a light-pen strobe coincides with a register read of the light-pen low byte. The bench raises `lpen_stb` in the very cycle of that read. It expects the read to return the old captured byte, the next status read to still show bit 6, and the following read to return the newly captured byte. In the second, an update strobe coincides with a write to index 31; the following status read must still show bit 7.

// File: rtl/crtc_regif_pkg.sv
package crtc_regif_pkg;

   localparam int unsigned DATA_W = 8;

   typedef enum logic [1:0] {
      OP_SEL  = 2'b00,
      OP_WR   = 2'b01,
      OP_STAT = 2'b10,
      OP_RD   = 2'b11
   } bus_op_e;

   // Stored width of each programmable register index.
   function automatic int unsigned reg_width(input int unsigned idx);
      case (idx)
         4, 6, 7, 10: reg_width = 7;
         5, 9, 11:    reg_width = 5;
         12, 14:      reg_width = 6;
         default:     reg_width = 8;
      endcase
   endfunction

endpackage

// File: rtl/crtc_regif_decode.sv
module crtc_regif_decode
   import crtc_regif_pkg::*;
(
   input  logic    cs_n,
   input  logic    en,
   input  logic    rw,
   input  logic    rs,
   output logic    act,
   output bus_op_e op
);
   always_comb begin
      act = !cs_n && en;
      op  = bus_op_e'({rw, rs});
   end
endmodule

// File: rtl/crtc_regif_file.sv
module crtc_regif_file
   import crtc_regif_pkg::*;
#(
   parameter int unsigned NUM_WR = 16,
   parameter int unsigned IDX_W  = 5,
   parameter int unsigned DW     = DATA_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [IDX_W-1:0]           wr_idx,
   input  logic [DW-1:0]              wr_data,
   output logic [NUM_WR-1:0][DW-1:0]  regs
);
   for (genvar i = 0; i < NUM_WR; i++) begin : g_reg
      localparam int unsigned W = reg_width(i);
      localparam logic [DW-1:0] MASK = DW'((64'd1 << W) - 64'd1);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs[i] <= '0;
         else if (wr_en && wr_idx == IDX_W'(i))
            regs[i] <= wr_data & MASK;
      end
   end
endmodule

// File: rtl/crtc_regif_flag.sv
module crtc_regif_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   // A set in the same cycle as a clear wins.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end
endmodule

// File: rtl/crtc_regif_lpen.sv
module crtc_regif_lpen #(
   parameter int unsigned ADDR_W = 14,
   parameter int unsigned DW     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stb,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd_clr,
   output logic [DW-1:0]     hi,
   output logic [DW-1:0]     lo,
   output logic              full
);
   localparam int unsigned HI_W = ADDR_W - DW;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi <= '0;
         lo <= '0;
      end else if (stb) begin
         hi <= DW'(addr[ADDR_W-1:DW]);
         lo <= addr[DW-1:0];
      end
   end

   crtc_regif_flag u_full (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (stb),
      .clr  (rd_clr),
      .q    (full)
   );

   if (HI_W < 1 || HI_W > DW) begin : g_bad_width
      $error("lpen: ADDR_W must lie between DW+1 and 2*DW");
   end
endmodule

// File: rtl/crtc_cpu_regif.sv
module crtc_cpu_regif
   import crtc_regif_pkg::*;
#(
   parameter int unsigned IDX_W   = 5,
   parameter int unsigned NUM_WR  = 16,
   parameter int unsigned RD_LO   = 10,
   parameter int unsigned UPD_IDX = 31,
   parameter int unsigned ADDR_W  = 14
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cs_n,
   input  logic                     en,
   input  logic                     rw,
   input  logic                     rs,
   input  logic [DATA_W-1:0]        wdata,
   output logic [DATA_W-1:0]        rdata,
   input  logic                     update_stb,
   input  logic                     lpen_stb,
   input  logic                     vblank_in,
   input  logic [ADDR_W-1:0]        cur_addr,
   output logic [NUM_WR*DATA_W-1:0] cfg_regs
);
   localparam int unsigned WR_IW  = $clog2(NUM_WR);
   localparam int unsigned LP_HI  = NUM_WR;
   localparam int unsigned LP_LO  = NUM_WR + 1;
   localparam int unsigned N_REGS = NUM_WR + 2;

   if (N_REGS > (1 << IDX_W) || UPD_IDX >= (1 << IDX_W) || UPD_IDX < N_REGS) begin : g_bad_idx
      $error("regif: pointer width too small or update index overlaps registers");
   end
   if (RD_LO >= NUM_WR || (1 << WR_IW) != NUM_WR) begin : g_bad_rd
      $error("regif: NUM_WR must be a power of two above RD_LO");
   end

   logic                      act;
   bus_op_e                   op;
   logic [IDX_W-1:0]          sel_q;
   logic [NUM_WR-1:0][DATA_W-1:0] regs;
   logic [DATA_W-1:0]         lp_hi, lp_lo;
   logic                      lpf_q, upd_q;
   logic                      wr_hit, rd_hit, st_hit;
   logic                      upd_clr, lpf_clr;
   logic [DATA_W-1:0]         rd_val, stat_val;

   crtc_regif_decode u_dec (
      .cs_n(cs_n), .en(en), .rw(rw), .rs(rs), .act(act), .op(op)
   );

   always_comb begin
      wr_hit = act && op == OP_WR;
      rd_hit = act && op == OP_RD;
      st_hit = act && op == OP_STAT;
   end

   // Pointer: only the low IDX_W data bits are kept.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sel_q <= '0;
      else if (act && op == OP_SEL)
         sel_q <= wdata[IDX_W-1:0];
   end

   crtc_regif_file #(.NUM_WR(NUM_WR), .IDX_W(IDX_W), .DW(DATA_W)) u_file (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_hit && sel_q < IDX_W'(NUM_WR)),
      .wr_idx (sel_q),
      .wr_data(wdata),
      .regs   (regs)
   );

   always_comb begin
      lpf_clr = rd_hit && (sel_q == IDX_W'(LP_HI) || sel_q == IDX_W'(LP_LO));
      upd_clr = (wr_hit || rd_hit) && sel_q == IDX_W'(UPD_IDX);
   end

   crtc_regif_lpen #(.ADDR_W(ADDR_W), .DW(DATA_W)) u_lpen (
      .clk   (clk),
      .rst_n (rst_n),
      .stb   (lpen_stb),
      .addr  (cur_addr),
      .rd_clr(lpf_clr),
      .hi    (lp_hi),
      .lo    (lp_lo),
      .full  (lpf_q)
   );

   crtc_regif_flag u_upd (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (update_stb),
      .clr  (upd_clr),
      .q    (upd_q)
   );

   // Read window: cursor/start range, light-pen pair, zero elsewhere.
   always_comb begin
      if (sel_q >= IDX_W'(RD_LO) && sel_q < IDX_W'(NUM_WR))
         rd_val = regs[sel_q[WR_IW-1:0]];
      else if (sel_q == IDX_W'(LP_HI))
         rd_val = lp_hi;
      else if (sel_q == IDX_W'(LP_LO))
         rd_val = lp_lo;
      else
         rd_val = '0;
      stat_val = {upd_q, lpf_q, vblank_in, {(DATA_W-3){1'b0}}};
      if (rd_hit)      rdata = rd_val;
      else if (st_hit) rdata = stat_val;
      else             rdata = '0;
   end

   for (genvar k = 0; k < NUM_WR; k++) begin : g_cfg
      assign cfg_regs[k*DATA_W +: DATA_W] = regs[k];
   end
endmodule

// File: rtl/crtc_regif_chk.sv
module crtc_regif_chk #(
   parameter int unsigned IDX_W   = 5,
   parameter int unsigned NUM_WR  = 16,
   parameter int unsigned RD_LO   = 10,
   parameter int unsigned UPD_IDX = 31,
   parameter int unsigned DW      = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cs_n,
   input logic               en,
   input logic               rw,
   input logic               rs,
   input logic [DW-1:0]      wdata,
   input logic [DW-1:0]      rdata,
   input logic               update_stb,
   input logic               lpen_stb,
   input logic               vblank_in,
   input logic [NUM_WR*DW-1:0] cfg_regs,
   input logic [IDX_W-1:0]   sel_q,
   input logic               upd_q,
   input logic               lpf_q
);
   logic act;
   assign act = !cs_n && en;

   assert_sel_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (act && !rw && !rs) |=> sel_q == $past(wdata[IDX_W-1:0]));

   assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !act |=> ($stable(sel_q) && $stable(cfg_regs)));

   assert_high_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (act && !rw && rs && sel_q >= IDX_W'(NUM_WR)) |=> $stable(cfg_regs));

   assert_wo_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (act && rw && rs && sel_q < IDX_W'(RD_LO)) |-> rdata == '0);

   assert_status_layout_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (act && rw && !rs) |-> (rdata[4:0] == 5'd0 && rdata[5] == vblank_in
                              && rdata[7] == upd_q && rdata[6] == lpf_q));

   assert_update_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      update_stb |=> upd_q);

   assert_update_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (act && rs && sel_q == IDX_W'(UPD_IDX) && !update_stb) |=> !upd_q);

   assert_lpen_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lpen_stb |=> lpf_q);

   assert_lpen_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (act && rw && rs && !lpen_stb &&
       (sel_q == IDX_W'(NUM_WR) || sel_q == IDX_W'(NUM_WR + 1))) |=> !lpf_q);
endmodule

bind crtc_cpu_regif crtc_regif_chk #(
   .IDX_W(IDX_W), .NUM_WR(NUM_WR), .RD_LO(RD_LO), .UPD_IDX(UPD_IDX), .DW(8)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .en(en), .rw(rw), .rs(rs),
   .wdata(wdata), .rdata(rdata), .update_stb(update_stb), .lpen_stb(lpen_stb),
   .vblank_in(vblank_in), .cfg_regs(cfg_regs), .sel_q(sel_q),
   .upd_q(upd_q), .lpf_q(lpf_q)
);

// File: tb/sim_crtc_cpu_regif.sv
module sim_crtc_cpu_regif;
   localparam int CLK_P = 10;

   logic         clk = 0, rst_n = 0;
   logic         cs_n = 1, en = 0, rw = 0, rs = 0;
   logic [7:0]   wdata = 0;
   logic [7:0]   rdata;
   logic         update_stb = 0, lpen_stb = 0, vblank_in = 0;
   logic [13:0]  cur_addr = 0;
   logic [127:0] cfg_regs;

   int checks = 0, errors = 0;
   bit done = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic [7:0] model[16];

   always #(CLK_P/2) clk = ~clk;

   crtc_cpu_regif u0 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .en(en), .rw(rw), .rs(rs),
      .wdata(wdata), .rdata(rdata), .update_stb(update_stb),
      .lpen_stb(lpen_stb), .vblank_in(vblank_in), .cur_addr(cur_addr),
      .cfg_regs(cfg_regs)
   );

   function automatic logic [7:0] wmask(input int i);
      case (i)
         4, 6, 7, 10: return 8'h7F;
         5, 9, 11:    return 8'h1F;
         12, 14:      return 8'h3F;
         default:     return 8'hFF;
      endcase
   endfunction

   task automatic check(input logic [7:0] act_v, input logic [7:0] exp_v, input string tag);
      checks++;
      if (act_v !== exp_v) begin
         errors++;
         $display("FAIL %s actual %02h expected %02h", tag, act_v, exp_v);
      end
   endtask

   // Monitor: pops an expected byte for every read cycle it sees.
   always @(negedge clk) begin
      if (!cs_n && en && rw) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL unexpected read actual %02h expected none", rdata);
         end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(rdata, e, t);
         end
      end
   end

   task automatic bus(input logic c, input logic e, input logic w, input logic s, input logic [7:0] d);
      cs_n = c; en = e; rw = w; rs = s; wdata = d;
      @(posedge clk); #1;
      cs_n = 1; en = 0; rw = 0; rs = 0; wdata = 0;
   endtask

   task automatic sel(input logic [7:0] d);  bus(0, 1, 0, 0, d); endtask
   task automatic wr(input logic [7:0] d);   bus(0, 1, 0, 1, d); endtask
   task automatic rd(input logic [7:0] e, input string t);
      exp_q.push_back(e); tag_q.push_back(t); bus(0, 1, 1, 1, 8'h00);
   endtask
   task automatic st(input logic [7:0] e, input string t);
      exp_q.push_back(e); tag_q.push_back(t); bus(0, 1, 1, 0, 8'h00);
   endtask

   task automatic cfg_all(input string t);
      for (int i = 0; i < 16; i++) check(cfg_regs[i*8 +: 8], model[i], t);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) model[i] = 8'h00;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(posedge clk); #1;

      // R10 reset state
      cfg_all("R10 reset cfg");
      st(8'h00, "R10 reset status");
      sel(8'd12); rd(8'h00, "R10 reset reg12");

      // R3 width masking on every programmable register
      for (int i = 0; i < 16; i++) begin
         sel(8'(i)); wr(8'hFF); model[i] = wmask(i);
         check(cfg_regs[i*8 +: 8], model[i], "R3 masked write");
      end
      // R5 read window
      for (int i = 0; i < 16; i++) begin
         sel(8'(i));
         rd((i >= 10) ? wmask(i) : 8'h00, "R5 readback");
      end
      sel(8'd31); rd(8'h00, "R5 reg31 reads zero");
      sel(8'd13); wr(8'h5A); model[13] = 8'h5A;
      check(rdata, 8'h00, "R5 idle rdata");

      // R2 pointer modulo 32
      sel(8'hEC); wr(8'hC3); model[12] = 8'h03;
      check(cfg_regs[12*8 +: 8], 8'h03, "R2 upper bits ignored");
      rd(8'h03, "R2 readback");

      // R1 inactive cycles
      bus(1, 1, 0, 1, 8'h11);
      bus(0, 0, 0, 1, 8'h22);
      bus(1, 1, 0, 0, 8'h0D);
      bus(0, 0, 0, 0, 8'h0D);
      cfg_all("R1 inactive no change");
      wr(8'h2B); model[12] = 8'h2B;
      check(cfg_regs[12*8 +: 8], 8'h2B, "R1 pointer kept");
      bus(0, 1, 0, 1, 8'h11); model[12] = 8'h11;
      check(cfg_regs[12*8 +: 8], 8'h11, "R1 op 01 is write");

      // R4 writes above 15 ignored
      sel(8'd20); wr(8'h77);
      sel(8'd16); wr(8'h12);
      sel(8'd17); wr(8'h34);
      cfg_all("R4 no effect");
      sel(8'd16); rd(8'h00, "R4 lpen hi untouched");
      sel(8'd17); rd(8'h00, "R4 lpen lo untouched");

      // R8 light-pen capture
      cur_addr = 14'h2ABC;
      lpen_stb = 1; @(posedge clk); #1 lpen_stb = 0;
      st(8'h40, "R8 full set");
      sel(8'd16); rd(8'h2A, "R8 hi byte");
      st(8'h00, "R9 full cleared by read");
      sel(8'd17); rd(8'hBC, "R8 lo byte");

      // R6 status bits, status read clears nothing
      vblank_in = 1;
      lpen_stb = 1; @(posedge clk); #1 lpen_stb = 0;
      st(8'h60, "R6 vblank and full");
      st(8'h60, "R6 status read keeps flags");
      vblank_in = 0;
      st(8'h40, "R6 vblank follows input");

      // R9 strobe and read of reg 17 in the same cycle
      cur_addr = 14'h1234;
      lpen_stb = 1; rd(8'hBC, "R9 read returns old value"); lpen_stb = 0;
      st(8'h40, "R9 set wins over clear");
      rd(8'h34, "R9 new lo byte");
      st(8'h00, "R9 cleared");
      sel(8'd16); rd(8'h12, "R8 new hi byte");

      // R7 update-ready
      update_stb = 1; @(posedge clk); #1 update_stb = 0;
      st(8'h80, "R7 set");
      sel(8'd31);
      st(8'h80, "R7 select does not clear");
      wr(8'h00);
      st(8'h00, "R7 write to 31 clears");
      update_stb = 1; @(posedge clk); #1 update_stb = 0;
      rd(8'h00, "R7 read of 31");
      st(8'h00, "R7 read of 31 clears");
      update_stb = 1; wr(8'h00); update_stb = 0;
      st(8'h80, "R7 set wins over clear");
      cfg_all("R4 write to 31 no effect");

      repeat (2) @(posedge clk);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual running expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule